// File: doc/BRIEF.md
# External Bus Controller with Bus Hand-Over

This block turns internal access requests from a processor core into two-clock external bus cycles. The address and write data go out on separate enable-qualified outputs, since the core may not drive the pins directly. Each request names a region. Internal space puts no strobe on the pins. Static external space uses chip select and read/write strobes. DRAM space uses row and column strobes. A per-request flag picks between an 8-bit and a 16-bit external data path.

An outside master can ask for the bus with an active-low request pin. The block finishes any cycle already in flight and then grants the bus. While the grant is held, the block releases its bus pins, stops the core and freezes the general-purpose outputs. It also tells the watchdog to pause.

The request side is valid/ready. A request moves only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low while an access is in progress, while a bus request is pending and while the grant is held. The core must keep `req_valid` and its fields stable until the transfer happens. The read response is a single-cycle `rsp_valid` pulse with no back-pressure, so the core must always take it.

Top module: `xbus_bridge`

## Requirements
- R1: After reset the bus is driven (`ctl_oe`=1) and every active-low strobe and select is high. In addition `addr_latch`=0, `data_oe`=0, `bus_gnt_n`=1, `wdt_stop`=0 and `bus_addr`=0. `req_ready`=1 when no bus request is pending.
- R2: Region codes are 0 internal, 1 static, 2 DRAM and 3 static. A static read lasts two clocks. The first clock has `addr_latch`=1, `sel_n`=0, the new `bus_addr` and all strobes high. The second clock has `addr_latch`=0, `sel_n`=0 and `rdstb_n`=0. In the clock after that, `rsp_valid`=1 and `rsp_rdata` holds `data_i` as sampled at the end of the second clock.
- R3: On a 16-bit static write, `wrstb_n` is low in the second clock. `wr_lo_n` is low there when byte enable bit 0 (the even byte) is set, and `wr_hi_n` is low when bit 1 (the odd byte) is set. `hi_lane_n` is the inverse of bit 1. `data_oe`=1 with `data_o` equal to the write data in both clocks.
- R4: On an 8-bit access, `hi_lane_n` and `wr_hi_n` stay high, `wr_lo_n` follows `wrstb_n`, and the read result is the low data byte zero-extended.
- R5: An internal access lasts two clocks, with `addr_latch`=1 in the first. `bus_addr` and `hi_lane_n` keep the values of the most recent external access. All strobes and `sel_n` stay high, and `data_oe`=0.
- R6: A 16-bit DRAM access holds `row_stb_n` low in both clocks. In the second clock, `col_lo_n` is low for the even byte and `col_hi_n` is low for the odd byte. `dram_we_n` is low only for writes. `sel_n`, `rdstb_n` and `wrstb_n` stay high.
- R7: An 8-bit DRAM access drives `col_lo_n` low in its second clock and keeps `col_hi_n` high.
- R8: The grant is given only between accesses. When `bus_req_n` goes low during an access, `bus_gnt_n` falls one clock after that access's last clock. `req_ready` is low from the clock in which the request is seen until the grant ends.
- R9: While `bus_gnt_n`=0, the following hold: `ctl_oe`=0, `data_oe`=0, `addr_latch`=0 and `wdt_stop`=1. DRAM strobes are high, and a valid request is not accepted.
- R10: `bus_gnt_n` returns high at the first clock edge that samples `bus_req_n` high. After that `ctl_oe`=1 and `bus_addr` still shows the last external address.
- R11: `gpio_q` follows `gpio_d` one clock late. It keeps the value it had on entering the grant until the grant ends.
- R12: `req_ready` is low during both clocks of an access and returns high in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 0 even byte, bit 1 odd byte |
| req_region | input | 2 | 0 internal, 1 static, 2 DRAM, 3 static |
| narrow_bus | input | 1 | 1 = 8-bit external path for this request |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data |
| bus_req_n | input | 1 | Outside master bus request, active low |
| bus_gnt_n | output | 1 | Bus grant, active low |
| wdt_stop | output | 1 | Watchdog pause during grant |
| gpio_d | input | GPIO_W | Port values from the core |
| gpio_q | output | GPIO_W | Port pin values |
| ctl_oe | output | 1 | Enable for address, strobes, select and byte-high lane |
| bus_addr | output | ADDR_W | External address |
| data_oe | output | 1 | Data output enable |
| data_o | output | 16 | Data out |
| data_i | input | 16 | Data in |
| sel_n | output | 1 | Static chip select |
| rdstb_n | output | 1 | Read strobe |
| wrstb_n | output | 1 | Write strobe |
| wr_lo_n | output | 1 | Even-byte write strobe |
| wr_hi_n | output | 1 | Odd-byte write strobe |
| hi_lane_n | output | 1 | High byte lane enable |
| addr_latch | output | 1 | Address latch enable |
| row_stb_n | output | 1 | DRAM row strobe |
| col_lo_n | output | 1 | DRAM even-byte column strobe |
| col_hi_n | output | 1 | DRAM odd-byte column strobe |
| dram_we_n | output | 1 | DRAM write enable |

## Verification
The bench puts a bus request in the middle of a read. A design that grants at once would float the pins while `rdstb_n` is low, and one that grants late would show the wrong `bus_gnt_n` edge. Internal accesses follow external ones with different byte enables. A design that updates the held address or lane enable on internal space would show the new values on `bus_addr` or `hi_lane_n`. Odd-byte and 8-bit accesses in both static and DRAM space catch swapped column or write strobes, and a high strobe wrongly asserted on the narrow path. `gpio_d` changes during the grant to expose a design that does not freeze `gpio_q`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int BUS_W = 16;

  typedef enum logic [1:0] {
    RGN_INT  = 2'd0,
    RGN_STAT = 2'd1,
    RGN_DRAM = 2'd2,
    RGN_ALT  = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADR  = 3'd1,
    PH_STB  = 3'd2,
    PH_IADR = 3'd3,
    PH_ISTB = 3'd4,
    PH_HOLD = 3'd5
  } phase_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    hold_req,
  input  logic    req_int,
  output logic    accept,
  output logic    ready,
  output phase_e  phase
);
  phase_e nxt;

  assign ready  = (phase == PH_IDLE) && !hold_req;
  assign accept = ready && req_valid;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: begin
        if (hold_req)      nxt = PH_HOLD;
        else if (req_valid) nxt = req_int ? PH_IADR : PH_ADR;
      end
      PH_ADR:  nxt = PH_STB;
      PH_STB:  nxt = PH_IDLE;
      PH_IADR: nxt = PH_ISTB;
      PH_ISTB: nxt = PH_IDLE;
      PH_HOLD: if (!hold_req) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end
endmodule

// File: rtl/xbus_lat.sv
module xbus_lat
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  phase_e            phase,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BUS_W-1:0]  req_wdata,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [1:0]        req_region,
  input  logic              narrow_bus,
  input  logic [BUS_W-1:0]  data_i,
  output logic              cur_wr,
  output logic [1:0]        cur_be,
  output logic              cur_dram,
  output logic              cur_narrow,
  output logic [BUS_W-1:0]  cur_wdata,
  output logic [ADDR_W-1:0] ext_addr,
  output logic              ext_hi_n,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata
);
  localparam int HALF = BUS_W / 2;
  logic ext_req;
  assign ext_req = req_region != RGN_INT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_wr     <= 1'b0;
      cur_be     <= '0;
      cur_dram   <= 1'b0;
      cur_narrow <= 1'b0;
      cur_wdata  <= '0;
      ext_addr   <= '0;
      ext_hi_n   <= 1'b1;
    end else if (accept) begin
      cur_wr     <= req_write;
      cur_be     <= req_be;
      cur_dram   <= req_region == RGN_DRAM;
      cur_narrow <= narrow_bus;
      cur_wdata  <= req_wdata;
      if (ext_req) begin
        ext_addr <= req_addr;
        ext_hi_n <= narrow_bus | ~req_be[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (phase == PH_STB) && !cur_wr;
      if ((phase == PH_STB) && !cur_wr)
        rsp_rdata <= cur_narrow ? {{HALF{1'b0}}, data_i[HALF-1:0]} : data_i;
    end
  end
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
(
  input  phase_e             phase,
  input  logic               cur_wr,
  input  logic [1:0]         cur_be,
  input  logic               cur_dram,
  input  logic               cur_narrow,
  input  logic [BUS_W-1:0]   cur_wdata,
  output logic               ctl_oe,
  output logic               data_oe,
  output logic [BUS_W-1:0]   data_o,
  output logic               addr_latch,
  output logic               sel_n,
  output logic               rdstb_n,
  output logic               wrstb_n,
  output logic               wr_lo_n,
  output logic               wr_hi_n,
  output logic               row_stb_n,
  output logic               col_lo_n,
  output logic               col_hi_n,
  output logic               dram_we_n,
  output logic               gnt_n,
  output logic               wdt_stop
);
  logic in_ext, in_stb, stat, lo_sel, hi_sel;

  assign in_ext = (phase == PH_ADR) || (phase == PH_STB);
  assign in_stb = phase == PH_STB;
  assign stat   = !cur_dram;
  assign lo_sel = cur_narrow || cur_be[0];
  assign hi_sel = !cur_narrow && cur_be[1];

  assign ctl_oe     = phase != PH_HOLD;
  assign gnt_n      = phase != PH_HOLD;
  assign wdt_stop   = phase == PH_HOLD;
  assign addr_latch = (phase == PH_ADR) || (phase == PH_IADR);
  assign data_oe    = in_ext && cur_wr;
  assign data_o     = cur_wdata;

  assign sel_n   = !(in_ext && stat);
  assign rdstb_n = !(in_stb && stat && !cur_wr);
  assign wrstb_n = !(in_stb && stat && cur_wr);
  assign wr_lo_n = !(in_stb && stat && cur_wr && lo_sel);
  assign wr_hi_n = !(in_stb && stat && cur_wr && hi_sel);

  assign row_stb_n = !(in_ext && cur_dram);
  assign col_lo_n  = !(in_stb && cur_dram && lo_sel);
  assign col_hi_n  = !(in_stb && cur_dram && hi_sel);
  assign dram_we_n = !(in_stb && cur_dram && cur_wr);
endmodule

// File: rtl/xbus_gpio.sv
module xbus_gpio #(
  parameter int GPIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  logic [GPIO_W-1:0] gpio_d,
  output logic [GPIO_W-1:0] gpio_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gpio_q <= '0;
    else if (!freeze) gpio_q <= gpio_d;
  end
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int GPIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [1:0]        req_region,
  input  logic              narrow_bus,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  input  logic              bus_req_n,
  output logic              bus_gnt_n,
  output logic              wdt_stop,
  input  logic [GPIO_W-1:0] gpio_d,
  output logic [GPIO_W-1:0] gpio_q,
  output logic              ctl_oe,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              data_oe,
  output logic [15:0]       data_o,
  input  logic [15:0]       data_i,
  output logic              sel_n,
  output logic              rdstb_n,
  output logic              wrstb_n,
  output logic              wr_lo_n,
  output logic              wr_hi_n,
  output logic              hi_lane_n,
  output logic              addr_latch,
  output logic              row_stb_n,
  output logic              col_lo_n,
  output logic              col_hi_n,
  output logic              dram_we_n
);
  phase_e            phase;
  logic              accept;
  logic              cur_wr, cur_dram, cur_narrow;
  logic [1:0]        cur_be;
  logic [BUS_W-1:0]  cur_wdata;

  xbus_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .hold_req(!bus_req_n), .req_int(req_region == RGN_INT),
    .accept(accept), .ready(req_ready), .phase(phase)
  );

  xbus_lat #(.ADDR_W(ADDR_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .accept(accept), .phase(phase),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_be(req_be), .req_region(req_region), .narrow_bus(narrow_bus),
    .data_i(data_i), .cur_wr(cur_wr), .cur_be(cur_be), .cur_dram(cur_dram),
    .cur_narrow(cur_narrow), .cur_wdata(cur_wdata), .ext_addr(bus_addr),
    .ext_hi_n(hi_lane_n), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  xbus_pins u_pins (
    .phase(phase), .cur_wr(cur_wr), .cur_be(cur_be), .cur_dram(cur_dram),
    .cur_narrow(cur_narrow), .cur_wdata(cur_wdata), .ctl_oe(ctl_oe),
    .data_oe(data_oe), .data_o(data_o), .addr_latch(addr_latch),
    .sel_n(sel_n), .rdstb_n(rdstb_n), .wrstb_n(wrstb_n), .wr_lo_n(wr_lo_n),
    .wr_hi_n(wr_hi_n), .row_stb_n(row_stb_n), .col_lo_n(col_lo_n),
    .col_hi_n(col_hi_n), .dram_we_n(dram_we_n), .gnt_n(bus_gnt_n),
    .wdt_stop(wdt_stop)
  );

  xbus_gpio #(.GPIO_W(GPIO_W)) u_gpio (
    .clk(clk), .rst_n(rst_n), .freeze(phase == PH_HOLD),
    .gpio_d(gpio_d), .gpio_q(gpio_q)
  );
endmodule

// File: rtl/xbus_bridge_chk.sv
module xbus_bridge_chk #(
  parameter int GPIO_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_gnt_n,
  input logic              wdt_stop,
  input logic              ctl_oe,
  input logic              data_oe,
  input logic              addr_latch,
  input logic              rdstb_n,
  input logic              wrstb_n,
  input logic              row_stb_n,
  input logic              col_lo_n,
  input logic [GPIO_W-1:0] gpio_q
);
  // R8
  grant_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_gnt_n) |-> $past(!addr_latch && rdstb_n && wrstb_n && row_stb_n));
  // R9
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt_n |-> (!ctl_oe && !data_oe && !addr_latch && wdt_stop && row_stb_n));
  // R2
  rd_after_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdstb_n |-> ($past(addr_latch) && !data_oe && wrstb_n));
  // R6
  col_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !col_lo_n |-> !row_stb_n);
  // R11
  gpio_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_gnt_n && $past(!bus_gnt_n)) |-> $stable(gpio_q));
  // R12
  ready_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_gnt_n && !addr_latch && rdstb_n && wrstb_n));
endmodule

bind xbus_bridge xbus_bridge_chk #(.GPIO_W(GPIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_gnt_n(bus_gnt_n),
  .wdt_stop(wdt_stop), .ctl_oe(ctl_oe), .data_oe(data_oe),
  .addr_latch(addr_latch), .rdstb_n(rdstb_n), .wrstb_n(wrstb_n),
  .row_stb_n(row_stb_n), .col_lo_n(col_lo_n), .gpio_q(gpio_q)
);

// File: tb/xbus_bridge_test.sv
module xbus_bridge_test;
  localparam int CLK_NS = 10;
  localparam int AW = 20;
  localparam int GW = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, narrow_bus = 0, bus_req_n = 1;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0, data_i = '0;
  logic [1:0] req_be = 2'b11, req_region = 2'd0;
  logic [GW-1:0] gpio_d = '0;
  logic req_ready, rsp_valid, bus_gnt_n, wdt_stop, ctl_oe, data_oe;
  logic [15:0] rsp_rdata, data_o;
  logic [GW-1:0] gpio_q;
  logic [AW-1:0] bus_addr;
  logic sel_n, rdstb_n, wrstb_n, wr_lo_n, wr_hi_n, hi_lane_n, addr_latch;
  logic row_stb_n, col_lo_n, col_hi_n, dram_we_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  logic [AW-1:0] last_addr = '0;
  logic last_hi_n = 1'b1;

  xbus_bridge #(.ADDR_W(AW), .GPIO_W(GW)) uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n && rsp_valid) begin
    if (exp_q.size() == 0) ck("R2 unexpected response", 1, 0);
    else ck("R2/R4 read data", rsp_rdata, exp_q.pop_front());
  end

  task automatic acc(input logic [1:0] rg, input logic [AW-1:0] a, input logic wr,
                     input logic [1:0] be, input logic nar, input logic [15:0] d);
    logic dram, stat, lo, hi;
    dram = rg == 2'd2; stat = (rg == 2'd1) || (rg == 2'd3);
    lo = nar || be[0]; hi = !nar && be[1];
    req_region = rg; req_addr = a; req_write = wr; req_be = be;
    narrow_bus = nar; req_wdata = d; req_valid = 1;
    step();
    req_valid = 0;
    if (rg != 2'd0) begin last_addr = a; last_hi_n = nar || !be[1]; end
    // first clock
    ck("R2/R5 latch pulse", addr_latch, 1);
    ck("R12 ready low clk1", req_ready, 0);
    ck("R5 addr", bus_addr, last_addr);
    ck("R5 hi lane", hi_lane_n, last_hi_n);
    ck("R2 select clk1", sel_n, !stat);
    ck("R6 row clk1", row_stb_n, !dram);
    ck("R3 data oe clk1", data_oe, wr && rg != 2'd0);
    if (!wr) data_i = d;
    if (!wr && rg != 2'd0) exp_q.push_back(nar ? {8'h00, d[7:0]} : d);
    step();
    ck("R2 latch low clk2", addr_latch, 0);
    ck("R12 ready low clk2", req_ready, 0);
    ck("R2 read strobe", rdstb_n, !(stat && !wr));
    ck("R3 write strobe", wrstb_n, !(stat && wr));
    ck("R3/R4 even write", wr_lo_n, !(stat && wr && lo));
    ck("R3/R4 odd write", wr_hi_n, !(stat && wr && hi));
    ck("R6/R7 even col", col_lo_n, !(dram && lo));
    ck("R6/R7 odd col", col_hi_n, !(dram && hi));
    ck("R6 dram we", dram_we_n, !(dram && wr));
    ck("R5 select clk2", sel_n, !stat);
    if (wr && rg != 2'd0) ck("R3 data out", data_o, d);
    step();
    ck("R12 ready back", req_ready, 1);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    gpio_d = 8'h11;
    #(CLK_NS * 2 + 1);
    // R1 reset state
    ck("R1 oe", ctl_oe, 1); ck("R1 strobes", {sel_n, rdstb_n, wrstb_n, wr_lo_n, wr_hi_n}, 5'h1f);
    ck("R1 dram", {row_stb_n, col_lo_n, col_hi_n, dram_we_n, hi_lane_n}, 5'h1f);
    ck("R1 misc", {addr_latch, data_oe, bus_gnt_n, wdt_stop}, 4'b0010);
    ck("R1 addr", bus_addr, 0);
    rst_n = 1; step();
    ck("R1 ready", req_ready, 1);
    ck("R11 gpio follows", gpio_q, 8'h11);

    acc(2'd1, 20'h12345, 0, 2'b11, 0, 16'hBEEF);   // R2
    acc(2'd1, 20'h00A10, 1, 2'b11, 0, 16'h1234);   // R3 word
    acc(2'd3, 20'h00A11, 1, 2'b10, 0, 16'hAB00);   // R3 odd byte
    acc(2'd0, 20'h0F000, 1, 2'b01, 0, 16'h5555);   // R5 keeps odd-lane state
    acc(2'd0, 20'h0F002, 0, 2'b11, 0, 16'h7777);   // R5 read
    acc(2'd1, 20'h00200, 1, 2'b11, 1, 16'h00C3);   // R4 narrow write
    acc(2'd1, 20'h00201, 0, 2'b11, 1, 16'hA55A);   // R4 narrow read
    acc(2'd2, 20'h40000, 1, 2'b11, 0, 16'hCAFE);   // R6 word write
    acc(2'd2, 20'h40003, 0, 2'b10, 0, 16'h9900);   // R6 odd read
    acc(2'd2, 20'h40004, 1, 2'b11, 1, 16'h0042);   // R7 narrow dram

    // R8 bus request during an access
    req_region = 2'd1; req_addr = 20'h03030; req_write = 0; req_be = 2'b11;
    narrow_bus = 0; req_valid = 1; data_i = 16'h3C3C;
    step(); req_valid = 0;
    exp_q.push_back(16'h3C3C);
    bus_req_n = 0;
    ck("R8 no grant mid access", bus_gnt_n, 1);
    step();
    ck("R8 read finishes", rdstb_n, 0);
    ck("R8 still driven", ctl_oe, 1);
    step();
    ck("R8 grant one clock after", bus_gnt_n, 1);
    ck("R8 ready low on request", req_ready, 0);
    gpio_d = 8'h22;
    step();
    ck("R8 grant", bus_gnt_n, 0);
    ck("R9 float", {ctl_oe, data_oe, addr_latch, wdt_stop}, 4'b0001);
    ck("R11 captured", gpio_q, 8'h22);
    gpio_d = 8'h33;
    req_region = 2'd1; req_addr = 20'h07777; req_valid = 1;
    step();
    ck("R9 no accept", {req_ready, addr_latch, row_stb_n}, 3'b001);
    ck("R11 frozen", gpio_q, 8'h22);
    req_valid = 0;
    bus_req_n = 1;
    step();
    ck("R10 grant ends", bus_gnt_n, 1);
    ck("R10 driven", ctl_oe, 1);
    ck("R10 addr kept", bus_addr, 20'h03030);
    ck("R10 wdt", wdt_stop, 0);
    step();
    ck("R11 follows again", gpio_q, 8'h33);
    ck("R12 ready after grant", req_ready, 1);
    ck("R2 scoreboard drained", exp_q.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule